// File: doc/BRIEF.md
# Low-Power Counter Register Bank

This block is the register file that sits between a simple synchronous bus and the counting core of a low-power counter. It holds the run control, the counting configuration (quadrature or plain counting, active clock edge, prescaler), the reload ceiling, the compare value and two completion flags. It also offers a read-only view of the live count value supplied by the core.

Software brings the counter up in a fixed order. It programs the configuration while the counter is off. It then sets the enable bit and writes the ceiling and compare values. It waits for their completion flags, clears them, and finally sets the start bit. The ceiling and compare writes do not land at once. Each is held for a fixed number of clock cycles before it is committed, and only then does its flag rise. Turning the counter off stops counting, asks the core to zero its count and cancels any write still in flight.

Top module: `lpcnt_regs`

## Requirements
- R1: After reset, the control, configuration, compare and status registers read 0, and the ceiling reads all ones (the largest value that fits in CW bits).
- R2: While disabled, a write to the configuration register (word 1) is stored. Its fields are: bit 0 quadrature mode, bit 1 external-count mode, bits 3:2 active edge (0 rising, 1 falling, 2 both), bits 6:4 prescaler. Each field drives its matching output.
- R3: While enabled, a write to the configuration register is dropped and the stored fields do not change.
- R4: While disabled, writes to the ceiling (word 2) and compare (word 3) registers are ignored: the value stays and no flag rises.
- R5: While enabled, a ceiling write is committed COMMIT_DLY (default 3) clock edges after the edge that takes it. On that same edge, status bit 0 (ceiling done) sets.
- R6: While enabled, a compare write is committed after the same delay, and status bit 1 (compare done) sets on the commit edge.
- R7: Writing 1 to a bit of the clear register (word 5) clears the status flag at the same bit position. Writing 0 there leaves that flag set. The clear register reads 0.
- R8: The control register (word 0) has bit 0 enable and bit 1 running. Enable is taken from bit 0 of each write. Counting starts only when a write with bits 0 and 1 both set arrives while enable is already 1. Setting enable alone does not start counting.
- R9: A control write with bit 0 clear turns off enable and running. If the counter was enabled, it pulses cnt_clear high for exactly one cycle.
- R10: The count register (word 6) reads the count_in value zero-extended.
- R11: Disabling the counter while a ceiling or compare write is pending cancels that write: the value stays unchanged and no flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr (combinational) |
| count_in | input | CW | Live count value from the counting core |
| tmr_en | output | 1 | Counter enabled |
| tmr_run | output | 1 | Continuous counting active |
| cnt_clear | output | 1 | One-cycle request to zero the count |
| enc_mode | output | 1 | Quadrature decoding selected |
| cnt_mode | output | 1 | Count external edges |
| edge_sel | output | 2 | Active edge selection |
| presc | output | 3 | Prescaler setting |
| reload_val | output | CW | Committed ceiling |
| compare_val | output | CW | Committed compare value |

## Verification
The hardest situation to reach from the ports is a pending write whose commit window is cut short, either by the counter being disabled or by the clear register racing the flags. The bench walks the bus one cycle per step. This lets it read the target register on each edge of the delay window and see the old value hold until the exact commit edge. It then issues a ceiling write and disables the counter inside the window, and reads back both the value and the flags after the window has closed.

// File: rtl/lpcnt_regs.sv
module lpcnt_regs #(
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int AW = 3,
  parameter int COMMIT_DLY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [CW-1:0] count_in,
  output logic          tmr_en,
  output logic          tmr_run,
  output logic          cnt_clear,
  output logic          enc_mode,
  output logic          cnt_mode,
  output logic [1:0]    edge_sel,
  output logic [2:0]    presc,
  output logic [CW-1:0] reload_val,
  output logic [CW-1:0] compare_val
);
  localparam int DLYW = $clog2(COMMIT_DLY + 1);
  localparam logic [AW-1:0] A_CTRL = 0, A_CFG = 1, A_ARR = 2, A_CMP = 3,
                            A_ISR = 4, A_ICR = 5, A_CNT = 6;

  logic [CW-1:0]   val  [2];
  logic [CW-1:0]   pend [2];
  logic [DLYW-1:0] dly  [2];
  logic [1:0]      ok_q, wr_val, commit;

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_off  = wr_ctrl && !bus_wdata[0];
  wire wr_cfg  = bus_wr && bus_addr == A_CFG;
  wire wr_icr  = bus_wr && bus_addr == A_ICR;
  assign wr_val = {bus_wr && bus_addr == A_CMP, bus_wr && bus_addr == A_ARR};

  assign reload_val  = val[0];
  assign compare_val = val[1];

  for (genvar i = 0; i < 2; i++) begin : g_slot
    assign commit[i] = dly[i] == DLYW'(1) && !wr_val[i] && !wr_off;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val[i]  <= (i == 0) ? '1 : '0;
        pend[i] <= '0;
        dly[i]  <= '0;
        ok_q[i] <= 1'b0;
      end else begin
        if (wr_off) dly[i] <= '0;
        else if (wr_val[i] && tmr_en) begin
          pend[i] <= bus_wdata[CW-1:0];
          dly[i]  <= DLYW'(COMMIT_DLY);
        end else if (dly[i] != '0) dly[i] <= dly[i] - DLYW'(1);
        if (commit[i]) val[i] <= pend[i];
        if (commit[i]) ok_q[i] <= 1'b1;
        else if (wr_icr && bus_wdata[i]) ok_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_en <= 1'b0; tmr_run <= 1'b0; cnt_clear <= 1'b0;
      enc_mode <= 1'b0; cnt_mode <= 1'b0; edge_sel <= '0; presc <= '0;
    end else begin
      cnt_clear <= 1'b0;
      if (wr_off) begin
        tmr_en    <= 1'b0;
        tmr_run   <= 1'b0;
        cnt_clear <= tmr_en;
      end else if (wr_ctrl) begin
        tmr_en <= 1'b1;
        if (bus_wdata[1] && tmr_en) tmr_run <= 1'b1;
      end
      if (wr_cfg && !tmr_en) begin
        enc_mode <= bus_wdata[0];
        cnt_mode <= bus_wdata[1];
        edge_sel <= bus_wdata[3:2];
        presc    <= bus_wdata[6:4];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = DW'({tmr_run, tmr_en});
      A_CFG:   bus_rdata = DW'({presc, edge_sel, cnt_mode, enc_mode});
      A_ARR:   bus_rdata = DW'(reload_val);
      A_CMP:   bus_rdata = DW'(compare_val);
      A_ISR:   bus_rdata = DW'(ok_q);
      A_CNT:   bus_rdata = DW'(count_in);
      default: bus_rdata = '0;
    endcase
  end
endmodule

module lpcnt_regs_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tmr_en,
  input logic          tmr_run,
  input logic          cnt_clear,
  input logic [6:0]    cfg,
  input logic [CW-1:0] reload_val,
  input logic [CW-1:0] compare_val,
  input logic [1:0]    ok_q
);
  // R3
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tmr_en) |-> $stable(cfg));
  // R5
  arr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reload_val) |-> $past(tmr_en) && ok_q[0]);
  // R6
  cmp_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(compare_val) |-> $past(tmr_en) && ok_q[1]);
  // R8
  run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_run) |-> $past(tmr_en));
  // R8
  run_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_run |-> tmr_en);
  // R9
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmr_en) |-> cnt_clear && !tmr_run);
  // R9
  clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> !cnt_clear);
endmodule

bind lpcnt_regs lpcnt_regs_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .tmr_run(tmr_run),
  .cnt_clear(cnt_clear), .cfg({presc, edge_sel, cnt_mode, enc_mode}),
  .reload_val(reload_val), .compare_val(compare_val), .ok_q(ok_q));

// File: tb/lpcnt_regs_test.sv
module lpcnt_regs_test;
  localparam int CW = 16, DW = 32, AW = 3;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [CW-1:0] count_in = '0, reload_val, compare_val;
  logic tmr_en, tmr_run, cnt_clear, enc_mode, cnt_mode;
  logic [1:0] edge_sel;
  logic [2:0] presc;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  lpcnt_regs uut (.*);

  typedef struct packed {
    logic       wr;
    logic [2:0] a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0] r;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd0, 32'h0, 32'h0,    4'd1},  // R1 control
    '{1'b0, 3'd2, 32'h0, 32'hFFFF, 4'd1},  // R1 ceiling
    '{1'b0, 3'd3, 32'h0, 32'h0,    4'd1},  // R1 compare
    '{1'b0, 3'd4, 32'h0, 32'h0,    4'd1},  // R1 status
    '{1'b0, 3'd1, 32'h0, 32'h0,    4'd1},  // R1 config
    '{1'b1, 3'd1, 32'h5B, 32'h0,   4'd2},  // R2 write config
    '{1'b0, 3'd1, 32'h0, 32'h5B,   4'd2},
    '{1'b1, 3'd2, 32'h1234, 32'h0, 4'd4},  // R4 ceiling while off
    '{1'b0, 3'd2, 32'h0, 32'hFFFF, 4'd4},
    '{1'b0, 3'd2, 32'h0, 32'hFFFF, 4'd4},
    '{1'b0, 3'd2, 32'h0, 32'hFFFF, 4'd4},
    '{1'b0, 3'd2, 32'h0, 32'hFFFF, 4'd4},
    '{1'b0, 3'd4, 32'h0, 32'h0,    4'd4},
    '{1'b1, 3'd0, 32'h1, 32'h0,    4'd8},  // R8 enable only
    '{1'b0, 3'd0, 32'h0, 32'h1,    4'd8},
    '{1'b1, 3'd1, 32'h0, 32'h0,    4'd3},  // R3 config while on
    '{1'b0, 3'd1, 32'h0, 32'h5B,   4'd3},
    '{1'b1, 3'd2, 32'h1234, 32'h0, 4'd5},  // R5 ceiling commit
    '{1'b0, 3'd2, 32'h0, 32'hFFFF, 4'd5},
    '{1'b0, 3'd2, 32'h0, 32'hFFFF, 4'd5},
    '{1'b0, 3'd4, 32'h0, 32'h0,    4'd5},
    '{1'b0, 3'd2, 32'h0, 32'h1234, 4'd5},
    '{1'b1, 3'd3, 32'h42, 32'h0,   4'd6},  // R6 compare commit
    '{1'b0, 3'd4, 32'h0, 32'h1,    4'd6},
    '{1'b0, 3'd3, 32'h0, 32'h0,    4'd6},
    '{1'b0, 3'd3, 32'h0, 32'h0,    4'd6},
    '{1'b0, 3'd4, 32'h0, 32'h3,    4'd6},
    '{1'b1, 3'd5, 32'h2, 32'h0,    4'd7},  // R7 clear compare flag
    '{1'b0, 3'd4, 32'h0, 32'h1,    4'd7},
    '{1'b1, 3'd5, 32'h0, 32'h0,    4'd7},  // R7 zero has no effect
    '{1'b0, 3'd4, 32'h0, 32'h1,    4'd7},
    '{1'b1, 3'd5, 32'h1, 32'h0,    4'd7},
    '{1'b0, 3'd4, 32'h0, 32'h0,    4'd7},
    '{1'b1, 3'd0, 32'h3, 32'h0,    4'd8},  // R8 start while enabled
    '{1'b0, 3'd0, 32'h0, 32'h3,    4'd8}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    step(1'b0, a, 32'h0);
    check(tag, bus_rdata, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    check("R1 clear idle", {31'b0, cnt_clear}, 32'h0);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].wr, VEC[i].a, VEC[i].d);
      if (!VEC[i].wr) check($sformatf("R%0d vector %0d", VEC[i].r, i), bus_rdata, VEC[i].e);
    end
    check("R2 fields", {24'b0, enc_mode, cnt_mode, edge_sel, presc, 1'b0},
          {24'b0, 1'b1, 1'b1, 2'd2, 3'd5, 1'b0});
    count_in = 16'hBEEF;
    rd(3'd6, 32'hBEEF, "R10");
    step(1'b1, 3'd0, 32'h0);
    step(1'b0, 3'd0, 32'h0);
    check("R9 clear pulse", {31'b0, cnt_clear}, 32'h1);
    check("R9 control off", bus_rdata, 32'h0);
    step(1'b0, 3'd0, 32'h0);
    check("R9 pulse one cycle", {31'b0, cnt_clear}, 32'h0);
    step(1'b1, 3'd0, 32'h2);
    rd(3'd0, 32'h0, "R8 start while off");
    step(1'b1, 3'd0, 32'h3);
    rd(3'd0, 32'h1, "R8 start with enable");
    step(1'b1, 3'd2, 32'h55);
    step(1'b1, 3'd0, 32'h0);
    step(1'b0, 3'd0, 32'h0);
    check("R9 second pulse", {31'b0, cnt_clear}, 32'h1);
    repeat (4) step(1'b0, 3'd2, 32'h0);
    rd(3'd2, 32'h1234, "R11 ceiling kept");
    rd(3'd4, 32'h0, "R11 no flag");
    rd(3'd5, 32'h0, "R7 clear reads zero");
    rst_n = 0;
    #1;
    rd(3'd2, 32'hFFFF, "R1 reset again");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule